// File: doc/BRIEF.md
# Compressed Min-Sum Check Message Unit

This block is the check-node half of a two-phase min-sum decoder for quasi-cyclic LDPC codes. In the check phase it accepts, once per parity row, the K variable-to-check values of that row (6-bit sign-magnitude). It folds them into a short record: the smallest magnitude, the runner-up magnitude, the column holding the smallest, and the K sign bits. That record is written into one word of an on-chip row store addressed by the row number. A full row of K messages is never stored.

In the variable phase the same row numbers are presented again, in any order. Each record is read back and expanded into K check-to-variable messages using an offset min-sum rule. The messages are summed into K signed, saturating column accumulators. A start pulse clears the sums before a pass. A row flagged as last makes the finished sums available on a valid/ready output. The block takes one row per cycle and has a fixed two-cycle pipeline.

Top module: `cmsg_unit`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, msg_valid is 0 and every column sum reads 0.
- R2: The stored record keeps the smallest and second-smallest input magnitude of the row and the column of the smallest. On equal magnitudes the lower column number is taken as the smallest, and the equal value becomes the second smallest.
- R3: Column j of a rebuilt message has magnitude (second smallest if j is the stored column, smallest otherwise) minus OFFSET, floored at 0. This equals the minimum over all other columns of the row, minus OFFSET, floored at 0.
- R4: Message format: bit 5 is the sign, bits 4:0 the magnitude, and column j sits at bits 6j+5:6j of in_msgs and msg_out. The rebuilt sign is the XOR of all K input signs of the row with column j's own sign. It is forced to 0 when the rebuilt magnitude is 0.
- R5: With phase_i=0 an accepted row writes its record at address in_row. With phase_i=1 an accepted row reads the record at in_row, and rows may be read in any order and any subset.
- R6: A row accepted with phase_i=1 at clock edge n gives msg_valid=1 with its K messages in the cycle after edge n+1, and msg_valid=0 in the cycle between.
- R7: Each column sum is a signed ACC_W-bit value, ACC_W = 6 + clog2(MAX_COLW). It adds every rebuilt message of its column and saturates at 2^(ACC_W-1)-1 and -2^(ACC_W-1).
- R8: A cycle with start_i=1 sets every column sum to 0 at the next edge.
- R9: A row accepted with phase_i=1 and in_last=1 raises out_valid together with the final sums after the second edge. out_valid and out_sums then hold until out_ready is 1. in_ready is 0 while out_valid is 1.
- R10: Rows accepted with phase_i=0 produce no msg_valid and leave the column sums unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_i | input | 1 | 0 = check update (store records), 1 = variable update (expand and sum) |
| start_i | input | 1 | Clears the column sums |
| in_valid | input | 1 | Row input valid |
| in_ready | output | 1 | Row input ready |
| in_row | input | ROW_W | Row address in the record store |
| in_last | input | 1 | Marks the final row of a variable-phase pass |
| in_msgs | input | K*6 | Variable-to-check values of the row (check phase) |
| msg_valid | output | 1 | Rebuilt messages valid |
| msg_out | output | K*6 | Rebuilt check-to-variable messages |
| out_valid | output | 1 | Column sums complete |
| out_ready | input | 1 | Column sums taken |
| out_sums | output | K*ACC_W | Signed column sums, column j at bits ACC_W*j upward |

## Verification
Saturation is the hardest state to reach from the ports. A column only reaches its clamp when every row gives it a large magnitude with the same rebuilt sign, and the sign depends on the parity of the whole row. The bench therefore rewrites all rows with one column negative and the rest positive at full magnitude. Summing them drives one column to the upper clamp and the others to the lower clamp in one pass. Ties and all-zero rows are written as fixed rows next to random ones. The expected values come from a full per-column minimum over the other columns, not from a compressed record.

// File: rtl/cmsg_pkg.sv
// Shared constants and helpers for the compressed min-sum check message unit.
// Assumes 6-bit sign-magnitude messages: bit 5 sign, bits 4:0 magnitude.
package cmsg_pkg;
    localparam int MSG_W = 6;
    localparam int MAG_W = MSG_W - 1;

    // Subtract a fixed offset from a magnitude, floored at zero.
    function automatic logic [MAG_W-1:0] mag_offset(input logic [MAG_W-1:0] mag,
                                                    input int off);
        int m;
        m = int'(mag) - off;
        if (m < 0) m = 0;
        return MAG_W'(m);
    endfunction
endpackage

// File: rtl/cmsg_compress.sv
// Reduces one row of K sign-magnitude messages to a record
// {signs[K-1:0], idx[IDX_W-1:0], min2[4:0], min1[4:0]}.
// Ties: the lower column keeps the min1 slot. Purely combinational.
module cmsg_compress
    import cmsg_pkg::*;
#(
    parameter int K     = 4,
    parameter int IDX_W = 2,
    parameter int REC_W = K + IDX_W + 2*MAG_W
) (
    input  logic [K*MSG_W-1:0] msgs_i,
    output logic [REC_W-1:0]   rec_o
);

    logic [MAG_W-1:0] m1, m2, mag;
    logic [IDX_W-1:0] ix;
    logic [K-1:0]     sg;

    // Scan the columns in ascending order, keeping the two smallest magnitudes.
    always_comb begin
        m1  = '1;
        m2  = '1;
        ix  = '0;
        sg  = '0;
        mag = '0;
        for (int j = 0; j < K; j++) begin
            mag   = msgs_i[j*MSG_W +: MAG_W];
            sg[j] = msgs_i[j*MSG_W + MAG_W];
            if (mag < m1) begin
                m2 = m1;
                m1 = mag;
                ix = IDX_W'(j);
            end else if (mag < m2) begin
                m2 = mag;
            end
        end
        rec_o = {sg, ix, m2, m1};
    end

endmodule

// File: rtl/cmsg_rmem.sv
// Row record store: one word per parity row, synchronous write and registered read.
// Assumes no read of a row in the same cycle as its write.
module cmsg_rmem #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int W     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);

    logic [W-1:0] mem [DEPTH];

    // Write port: storage array is not reset.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Read port: registered output.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (re_i) rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/cmsg_expand.sv
// Rebuilds the K check-to-variable messages of one row from its record
// using offset min-sum. A zero magnitude always carries a positive sign.
module cmsg_expand
    import cmsg_pkg::*;
#(
    parameter int K      = 4,
    parameter int IDX_W  = 2,
    parameter int REC_W  = K + IDX_W + 2*MAG_W,
    parameter int OFFSET = 1
) (
    input  logic [REC_W-1:0]   rec_i,
    output logic [K*MSG_W-1:0] msgs_o
);

    logic [MAG_W-1:0] m1, m2;
    logic [IDX_W-1:0] ix;
    logic [K-1:0]     sg;
    logic             par;

    assign m1  = rec_i[MAG_W-1:0];
    assign m2  = rec_i[2*MAG_W-1:MAG_W];
    assign ix  = rec_i[2*MAG_W +: IDX_W];
    assign sg  = rec_i[2*MAG_W+IDX_W +: K];
    assign par = ^sg;

    for (genvar g = 0; g < K; g++) begin : g_col
        logic [MAG_W-1:0] raw, mag;
        // Pick the magnitude this column sees, then apply the offset.
        assign raw = (ix == IDX_W'(g)) ? m2 : m1;
        assign mag = mag_offset(raw, OFFSET);
        assign msgs_o[g*MSG_W +: MSG_W] = {(mag != '0) & (par ^ sg[g]), mag};
    end

endmodule

// File: rtl/cmsg_accum.sv
// K signed saturating column accumulators fed with sign-magnitude messages.
// Clear has priority over add.
module cmsg_accum
    import cmsg_pkg::*;
#(
    parameter int K     = 4,
    parameter int ACC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               add_i,
    input  logic [K*MSG_W-1:0] msgs_i,
    output logic [K*ACC_W-1:0] sums_o
);

    localparam logic signed [ACC_W:0] SUM_MAX = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] SUM_MIN = ~SUM_MAX;

    for (genvar g = 0; g < K; g++) begin : g_acc
        logic signed [ACC_W-1:0] acc, acc_n;
        logic signed [ACC_W:0]   mg, term, nxt;

        // Convert the message to two's complement and form the clamped sum.
        always_comb begin
            mg   = $signed({{(ACC_W+1-MAG_W){1'b0}}, msgs_i[g*MSG_W +: MAG_W]});
            term = msgs_i[g*MSG_W + MAG_W] ? -mg : mg;
            nxt  = $signed({acc[ACC_W-1], acc}) + term;
            if (nxt > SUM_MAX)      acc_n = SUM_MAX[ACC_W-1:0];
            else if (nxt < SUM_MIN) acc_n = SUM_MIN[ACC_W-1:0];
            else                    acc_n = nxt[ACC_W-1:0];
        end

        // Accumulator register with clear.
        always_ff @(posedge clk) begin
            if (!rst_n)     acc <= '0;
            else if (clr_i) acc <= '0;
            else if (add_i) acc <= acc_n;
        end

        assign sums_o[g*ACC_W +: ACC_W] = acc;
    end

endmodule

// File: rtl/cmsg_unit.sv
// Compressed min-sum check message unit (top).
// Check phase: row -> compress -> stage register -> record store (2 cycles).
// Variable phase: row -> store read -> expand -> message register and sums (2 cycles).
// Assumes start_i is pulsed only while the pipeline is empty.
module cmsg_unit
    import cmsg_pkg::*;
#(
    parameter  int K        = 4,
    parameter  int ROWS     = 8,
    parameter  int MAX_COLW = 4,
    parameter  int OFFSET   = 1,
    localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int IDX_W    = (K > 1) ? $clog2(K) : 1,
    localparam int ACC_W    = MSG_W + ((MAX_COLW > 1) ? $clog2(MAX_COLW) : 1),
    localparam int REC_W    = K + IDX_W + 2*MAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_i,
    input  logic               start_i,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ROW_W-1:0]   in_row,
    input  logic               in_last,
    input  logic [K*MSG_W-1:0] in_msgs,
    output logic               msg_valid,
    output logic [K*MSG_W-1:0] msg_out,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [K*ACC_W-1:0] out_sums
);

    logic             fire, chk_fire, var_fire;
    logic [REC_W-1:0] rec_c, wr_rec_q, rd_rec;
    logic [ROW_W-1:0] wr_row_q;
    logic             wr_en_q, rd_v_q, last_q, out_valid_q;
    logic [K*MSG_W-1:0] msg_c;

    assign fire     = in_valid & in_ready;
    assign chk_fire = fire & ~phase_i;
    assign var_fire = fire & phase_i;
    assign in_ready = ~out_valid_q & ~last_q;

    cmsg_compress #(.K(K), .IDX_W(IDX_W), .REC_W(REC_W)) u_comp (
        .msgs_i(in_msgs),
        .rec_o (rec_c)
    );

    // Check-phase stage register ahead of the store write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q  <= 1'b0;
            wr_row_q <= '0;
            wr_rec_q <= '0;
        end else begin
            wr_en_q <= chk_fire;
            if (chk_fire) begin
                wr_row_q <= in_row;
                wr_rec_q <= rec_c;
            end
        end
    end

    cmsg_rmem #(.DEPTH(ROWS), .AW(ROW_W), .W(REC_W)) u_rmem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_en_q),
        .waddr_i(wr_row_q),
        .wdata_i(wr_rec_q),
        .re_i   (var_fire),
        .raddr_i(in_row),
        .rdata_o(rd_rec)
    );

    // Variable-phase control: record-read valid and last-row marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            rd_v_q <= var_fire;
            last_q <= var_fire & in_last;
        end
    end

    cmsg_expand #(.K(K), .IDX_W(IDX_W), .REC_W(REC_W), .OFFSET(OFFSET)) u_exp (
        .rec_i (rd_rec),
        .msgs_o(msg_c)
    );

    // Output register for the rebuilt messages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_out   <= '0;
        end else begin
            msg_valid <= rd_v_q;
            if (rd_v_q) msg_out <= msg_c;
        end
    end

    cmsg_accum #(.K(K), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_i),
        .add_i (rd_v_q),
        .msgs_i(msg_c),
        .sums_o(out_sums)
    );

    // Column-sum handshake: raised by the last row, dropped when taken.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid_q <= 1'b0;
        else if (last_q)    out_valid_q <= 1'b1;
        else if (out_ready) out_valid_q <= 1'b0;
    end

    assign out_valid = out_valid_q;

endmodule

// File: rtl/cmsg_unit_chk.sv
// Assertion checker for cmsg_unit, attached by bind below.
module cmsg_unit_chk #(
    parameter int K     = 4,
    parameter int ACC_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               phase_i,
    input logic               start_i,
    input logic               in_valid,
    input logic               in_ready,
    input logic               msg_valid,
    input logic [K*6-1:0]     msg_out,
    input logic               out_valid,
    input logic               out_ready,
    input logic [K*ACC_W-1:0] out_sums
);

    // R6: an accepted variable-phase row yields messages two edges later.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && phase_i) |-> ##2 msg_valid);

    // R10: messages only follow an accepted variable-phase row.
    p_no_stray_msg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(in_valid && in_ready && phase_i, 2));

    // R9: no new rows while sums wait to be taken.
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9: pending sums hold until taken.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sums)));

    // R8: start clears every column sum.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (out_sums == '0));

    // R4: a zero magnitude never carries a negative sign.
    always @(posedge clk) begin
        if (rst_n && msg_valid) begin
            for (int j = 0; j < K; j++) begin
                p_zero_sign_r4: assert (msg_out[j*6 +: 5] != 5'd0 || !msg_out[j*6+5]);
            end
        end
    end

endmodule

bind cmsg_unit cmsg_unit_chk #(.K(K), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase_i),
    .start_i  (start_i),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .msg_valid(msg_valid),
    .msg_out  (msg_out),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_sums (out_sums)
);

// File: tb/cmsg_unit_test.sv
`timescale 1ns/1ps
module cmsg_unit_test;
    localparam int K = 4, ROWS = 8, MAX_COLW = 4, OFFSET = 1, ACC_W = 8, MW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic phase_i = 1'b0, start_i = 1'b0, in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic [2:0] in_row = '0;
    logic [K*MW-1:0] in_msgs = '0;
    logic in_ready, msg_valid, out_valid;
    logic [K*MW-1:0] msg_out;
    logic [K*ACC_W-1:0] out_sums;

    cmsg_unit #(.K(K), .ROWS(ROWS), .MAX_COLW(MAX_COLW), .OFFSET(OFFSET)) uut (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .start_i(start_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row), .in_last(in_last),
        .in_msgs(in_msgs), .msg_valid(msg_valid), .msg_out(msg_out),
        .out_valid(out_valid), .out_ready(out_ready), .out_sums(out_sums)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    int smag [ROWS][K];
    bit ssgn [ROWS][K];
    int esum [K];

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [K*MW-1:0] mkrow(int m0, int m1, int m2, int m3, logic [3:0] sg);
        return {sg[3], 5'(m3), sg[2], 5'(m2), sg[1], 5'(m1), sg[0], 5'(m0)};
    endfunction

    // Full min-sum: minimum and sign product over all other columns.
    function automatic int model_msg(int r, int c);
        int m = 31;
        bit s = 1'b0;
        for (int j = 0; j < K; j++) begin
            if (j != c) begin
                if (smag[r][j] < m) m = smag[r][j];
                s ^= ssgn[r][j];
            end
        end
        m = m - OFFSET;
        if (m < 0) m = 0;
        if (m == 0) s = 1'b0;
        return (int'(s) << 5) | m;
    endfunction

    function automatic int code_val(int code);
        return code[5] ? -(code & 31) : (code & 31);
    endfunction

    function automatic int sat(int v);
        int hi = (1 << (ACC_W-1)) - 1;
        int lo = -(1 << (ACC_W-1));
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic int sum_at(int c);
        logic signed [ACC_W-1:0] s;
        s = out_sums[c*ACC_W +: ACC_W];
        return int'(s);
    endfunction

    task automatic check_sums(input string tag);
        for (int c = 0; c < K; c++) check(sum_at(c), esum[c], {tag, " column sum"});
    endtask

    task automatic write_row(input int r, input logic [K*MW-1:0] v);
        for (int c = 0; c < K; c++) begin
            smag[r][c] = int'(v[c*MW +: 5]);
            ssgn[r][c] = v[c*MW+5];
        end
        @(negedge clk);
        phase_i = 1'b0; in_valid = 1'b1; in_row = 3'(r); in_msgs = v; in_last = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(int'(msg_valid), 0, "R10 msg_valid after check row");
        @(posedge clk);
        @(negedge clk);
        check(int'(msg_valid), 0, "R10 msg_valid two cycles after check row");
        check_sums("R10");
    endtask

    task automatic read_row(input int r, input bit last, input string tag);
        @(negedge clk);
        check(int'(in_ready), 1, {tag, " in_ready before row"});
        phase_i = 1'b1; in_valid = 1'b1; in_row = 3'(r); in_last = last;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check(int'(msg_valid), 0, "R6 msg_valid one cycle after accept");
        @(posedge clk);
        @(negedge clk);
        check(int'(msg_valid), 1, "R6 msg_valid two cycles after accept");
        for (int c = 0; c < K; c++) begin
            int e = model_msg(r, c);
            check(int'(msg_out[c*MW +: 5]), e & 31, {tag, " R2/R3 magnitude"});
            check(int'(msg_out[c*MW+5]), (e >> 5) & 1, {tag, " R4 sign"});
            esum[c] = sat(esum[c] + code_val(e));
        end
        check_sums({tag, " R7"});
        if (last) begin
            check(int'(out_valid), 1, "R9 out_valid after last row");
            check(int'(in_ready), 0, "R9 in_ready while sums pending");
        end
    endtask

    task automatic release_sums();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(int'(out_valid), 1, "R9 out_valid held");
            check_sums("R9 held");
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        check(int'(out_valid), 0, "R9 out_valid after take");
        check(int'(in_ready), 1, "R9 in_ready after take");
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < K; c++) esum[c] = 0;
        check_sums("R8 cleared");
    endtask

    task automatic t_reset();
        check(int'(in_ready), 1, "R1 in_ready");
        check(int'(out_valid), 0, "R1 out_valid");
        check(int'(msg_valid), 0, "R1 msg_valid");
        for (int c = 0; c < K; c++) esum[c] = 0;
        check_sums("R1");
    endtask

    task automatic t_store_rows();
        write_row(0, K*MW'($urandom()));
        write_row(1, mkrow(9, 9, 9, 9, 4'b0101));
        write_row(2, mkrow(0, 0, 0, 0, 4'b1010));
        write_row(3, mkrow(20, 3, 3, 17, 4'b0011));
        write_row(4, mkrow(31, 31, 31, 31, 4'b1111));
        write_row(5, mkrow(1, 2, 30, 31, 4'b0100));
        write_row(6, K*MW'($urandom()));
        write_row(7, K*MW'($urandom()));
    endtask

    task automatic t_forward_pass();
        pulse_start();
        for (int r = 0; r < ROWS; r++) read_row(r, r == ROWS-1, "R5 forward");
        release_sums();
    endtask

    task automatic t_reordered_subset();
        pulse_start();
        read_row(6, 1'b0, "R5 reorder");
        read_row(3, 1'b0, "R5 reorder");
        read_row(1, 1'b1, "R5 reorder");
        release_sums();
    endtask

    task automatic t_saturate();
        for (int r = 0; r < ROWS; r++) write_row(r, mkrow(31, 31, 31, 31, 4'b0001));
        pulse_start();
        for (int r = 0; r < ROWS; r++) read_row(r, r == ROWS-1, "R7 saturate");
        check(sum_at(0), 127, "R7 upper clamp");
        check(sum_at(1), -128, "R7 lower clamp");
        release_sums();
    endtask

    task automatic t_clear();
        pulse_start();
        check(int'(out_valid), 0, "R8 out_valid after clear");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_rows();
        t_forward_pass();
        t_reordered_subset();
        t_saturate();
        t_clear();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        summary();
        $finish;
    end

endmodule